// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit works out where a processor goes after a jump, call or conditional branch instruction. Each request carries the address of the next sequential instruction, an instruction kind code and every operand any branch form might need. The unit picks a target, decides whether the branch is taken, and returns the next program counter, the taken flag, the carry flag as a compare-and-branch leaves it, and the decremented count for decrement-and-branch. Saving and restoring return addresses for calls and returns is handled elsewhere. The caller supplies the call target fields exactly as for the matching jump.

A request is presented with `inValid` high for one clock. All results are registered and appear, with `outValid` high, on the next clock edge. Between requests the result registers hold their last values. Target arithmetic wraps modulo 2^16, and byte arithmetic wraps modulo 2^8.

Top module: `branch_unit`

## Requirements
- R1: While `rstN` is low, `outValid`, `taken`, `carryOut`, `nextPc` and `decResult` are all 0.
- R2: A request with `inValid` high gives `outValid` high exactly one clock edge later. A cycle with `inValid` low gives `outValid` low one edge later, and leaves `nextPc`, `taken`, `carryOut` and `decResult` unchanged.
- R3: Kind 0 (short jump) is always taken. Its target is `seqPc` plus `relOff` sign-extended to 16 bits, modulo 2^16.
- R4: Kind 1 (long jump or long call) is always taken. Its target is `longAddr`.
- R5: Kind 2 (absolute jump or call) is always taken. Its target is {`seqPc`[15:11], `opByte`[7:5], `addrLo`}, so it stays in the 2K page of the already-advanced PC.
- R6: Kind 3 (indirect jump) is always taken. Its target is `dptr` plus zero-extended `accIn`, modulo 2^16.
- R7: Kind 4 branches to the relative target (as in R3) when `accIn` is 0. Kind 5 branches there when `accIn` is not 0.
- R8: Kind 6 branches to the relative target when `carryIn` is 1. Kind 7 branches there when `carryIn` is 0.
- R9: Kind 8 branches to the relative target when `bitVal` is 1. Kind 9 branches there when `bitVal` is 0.
- R10: Kind 10 (compare) branches to the relative target when `cmpA` differs from `cmpB`. It sets `carryOut` to 1 when `cmpA` is less than `cmpB` as unsigned values, and to 0 otherwise. For every other kind, `carryOut` equals `carryIn`.
- R11: Kind 11 (decrement) outputs `decResult` = `decOperand` − 1 modulo 256, so 00h becomes FFh. It branches to the relative target when that result is nonzero. For every other kind, `decResult` equals `decOperand`.
- R12: When a branch is not taken, `nextPc` equals `seqPc`. Kind codes 12 to 15 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| kind | input | 4 | Instruction kind code |
| seqPc | input | 16 | Address of the next sequential instruction |
| relOff | input | 8 | Signed relative displacement |
| opByte | input | 8 | First opcode byte of an absolute jump or call |
| addrLo | input | 8 | Second byte of an absolute jump or call |
| longAddr | input | 16 | Full 16-bit target |
| accIn | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| carryIn | input | 1 | Current carry flag |
| bitVal | input | 1 | Value of the tested bit |
| cmpA | input | 8 | First compare operand |
| cmpB | input | 8 | Second compare operand |
| decOperand | input | 8 | Count before the decrement |
| outValid | output | 1 | Result strobe |
| nextPc | output | 16 | Next program counter |
| taken | output | 1 | Branch taken |
| carryOut | output | 1 | Carry flag after the instruction |
| decResult | output | 8 | Count after the decrement |

## Verification
Every result is due on the first clock edge after the request edge. The bench drives each request on a falling edge, lets one rising edge pass, and reads all five outputs on the next falling edge. It compares them with a bench-side model of the kind rules. After that it drives an idle cycle carrying different operands, and checks one edge later that `outValid` has dropped and that every result register still holds its value.

// File: rtl/branch_pkg.sv
package branch_pkg;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    K_SHORT  = 4'd0,
    K_LONG   = 4'd1,
    K_ABS    = 4'd2,
    K_IND    = 4'd3,
    K_ZERO   = 4'd4,
    K_NZERO  = 4'd5,
    K_CY     = 4'd6,
    K_NCY    = 4'd7,
    K_BIT    = 4'd8,
    K_NBIT   = 4'd9,
    K_CMPNE  = 4'd10,
    K_DECNZ  = 4'd11
  } kind_e;

  typedef enum logic [2:0] {
    TGT_SEQ,
    TGT_REL,
    TGT_LONG,
    TGT_ABS,
    TGT_IND
  } tgt_e;

  typedef enum logic [2:0] {
    COND_NEVER,
    COND_ALWAYS,
    COND_ACCZ,
    COND_CARRY,
    COND_BIT,
    COND_NEQ,
    COND_DECNZ
  } cond_e;

  typedef struct packed {
    tgt_e  tgtSel;
    cond_e condSel;
    logic  invert;
    logic  cmpCarry;
    logic  decEn;
  } ctrl_t;
endpackage

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import branch_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  output ctrl_t             ctrl
);
  always_comb begin
    ctrl = '{tgtSel: TGT_SEQ, condSel: COND_NEVER, invert: 1'b0,
             cmpCarry: 1'b0, decEn: 1'b0};
    case (kind)
      K_SHORT: begin ctrl.tgtSel = TGT_REL;  ctrl.condSel = COND_ALWAYS; end
      K_LONG:  begin ctrl.tgtSel = TGT_LONG; ctrl.condSel = COND_ALWAYS; end
      K_ABS:   begin ctrl.tgtSel = TGT_ABS;  ctrl.condSel = COND_ALWAYS; end
      K_IND:   begin ctrl.tgtSel = TGT_IND;  ctrl.condSel = COND_ALWAYS; end
      K_ZERO:  begin ctrl.tgtSel = TGT_REL;  ctrl.condSel = COND_ACCZ; end
      K_NZERO: begin ctrl.tgtSel = TGT_REL;  ctrl.condSel = COND_ACCZ;  ctrl.invert = 1'b1; end
      K_CY:    begin ctrl.tgtSel = TGT_REL;  ctrl.condSel = COND_CARRY; end
      K_NCY:   begin ctrl.tgtSel = TGT_REL;  ctrl.condSel = COND_CARRY; ctrl.invert = 1'b1; end
      K_BIT:   begin ctrl.tgtSel = TGT_REL;  ctrl.condSel = COND_BIT; end
      K_NBIT:  begin ctrl.tgtSel = TGT_REL;  ctrl.condSel = COND_BIT;   ctrl.invert = 1'b1; end
      K_CMPNE: begin
        ctrl.tgtSel   = TGT_REL;
        ctrl.condSel  = COND_NEQ;
        ctrl.cmpCarry = 1'b1;
      end
      K_DECNZ: begin
        ctrl.tgtSel  = TGT_REL;
        ctrl.condSel = COND_DECNZ;
        ctrl.decEn   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/branch_dpath.sv
module branch_dpath
  import branch_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int ABS_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  ctrl_t             ctrl,
  input  logic [PC_W-1:0]   seqPc,
  input  logic [DATA_W-1:0] relOff,
  input  logic [DATA_W-1:0] opByte,
  input  logic [DATA_W-1:0] addrLo,
  input  logic [PC_W-1:0]   longAddr,
  input  logic [DATA_W-1:0] accIn,
  input  logic [PC_W-1:0]   dptr,
  input  logic              carryIn,
  input  logic              bitVal,
  input  logic [DATA_W-1:0] cmpA,
  input  logic [DATA_W-1:0] cmpB,
  input  logic [DATA_W-1:0] decOperand,
  output logic              outValid,
  output logic [PC_W-1:0]   nextPc,
  output logic              taken,
  output logic              carryOut,
  output logic [DATA_W-1:0] decResult
);
  localparam int EXT_W  = PC_W - DATA_W;
  localparam int PAGE_W = PC_W - ABS_W;
  localparam int HI_W   = ABS_W - DATA_W;

  logic [PC_W-1:0]   relTgt, absTgt, indTgt, tgt;
  logic [DATA_W-1:0] decVal;
  logic              condRaw, takeNow, cyNow;

  assign relTgt = seqPc + {{EXT_W{relOff[DATA_W-1]}}, relOff};
  assign absTgt = {seqPc[PC_W-1 -: PAGE_W], opByte[DATA_W-1 -: HI_W], addrLo};
  assign indTgt = dptr + {{EXT_W{1'b0}}, accIn};
  assign decVal = decOperand - {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    case (ctrl.tgtSel)
      TGT_REL:  tgt = relTgt;
      TGT_LONG: tgt = longAddr;
      TGT_ABS:  tgt = absTgt;
      TGT_IND:  tgt = indTgt;
      default:  tgt = seqPc;
    endcase
  end

  always_comb begin
    case (ctrl.condSel)
      COND_ALWAYS: condRaw = 1'b1;
      COND_ACCZ:   condRaw = (accIn == '0);
      COND_CARRY:  condRaw = carryIn;
      COND_BIT:    condRaw = bitVal;
      COND_NEQ:    condRaw = (cmpA != cmpB);
      COND_DECNZ:  condRaw = (decVal != '0);
      default:     condRaw = 1'b0;
    endcase
  end

  assign takeNow = condRaw ^ ctrl.invert;
  assign cyNow   = ctrl.cmpCarry ? (cmpA < cmpB) : carryIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      nextPc    <= '0;
      taken     <= 1'b0;
      carryOut  <= 1'b0;
      decResult <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        nextPc    <= takeNow ? tgt : seqPc;
        taken     <= takeNow;
        carryOut  <= cyNow;
        decResult <= ctrl.decEn ? decVal : decOperand;
      end
    end
  end
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [3:0]  kind,
  input  logic [15:0] seqPc,
  input  logic [7:0]  relOff,
  input  logic [7:0]  opByte,
  input  logic [7:0]  addrLo,
  input  logic [15:0] longAddr,
  input  logic [7:0]  accIn,
  input  logic [15:0] dptr,
  input  logic        carryIn,
  input  logic        bitVal,
  input  logic [7:0]  cmpA,
  input  logic [7:0]  cmpB,
  input  logic [7:0]  decOperand,
  output logic        outValid,
  output logic [15:0] nextPc,
  output logic        taken,
  output logic        carryOut,
  output logic [7:0]  decResult
);
  ctrl_t ctrl;

  branch_ctrl uCtrl (.kind(kind), .ctrl(ctrl));

  branch_dpath #(.PC_W(16), .DATA_W(8), .ABS_W(11)) uDpath (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl),
    .seqPc(seqPc), .relOff(relOff), .opByte(opByte), .addrLo(addrLo),
    .longAddr(longAddr), .accIn(accIn), .dptr(dptr), .carryIn(carryIn),
    .bitVal(bitVal), .cmpA(cmpA), .cmpB(cmpB), .decOperand(decOperand),
    .outValid(outValid), .nextPc(nextPc), .taken(taken),
    .carryOut(carryOut), .decResult(decResult)
  );
endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [3:0]  kind,
  input logic [15:0] seqPc,
  input logic [15:0] longAddr,
  input logic [7:0]  cmpA,
  input logic [7:0]  cmpB,
  input logic [7:0]  decOperand,
  input logic        outValid,
  input logic [15:0] nextPc,
  input logic        taken,
  input logic        carryOut,
  input logic [7:0]  decResult
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(nextPc) && $stable(taken) && $stable(carryOut) && $stable(decResult)));
  assert_long_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && kind == 4'd1) |=> (taken && nextPc == $past(longAddr)));
  assert_cmp_branch_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && kind == 4'd10) |=> (taken == ($past(cmpA) != $past(cmpB)) &&
                                    carryOut == ($past(cmpA) < $past(cmpB))));
  assert_dec_value_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && kind == 4'd11) |=> (decResult == $past(decOperand) - 8'd1));
  assert_fallthrough_R12: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && kind >= 4'd12) |=> (!taken && nextPc == $past(seqPc)));
endmodule

bind branch_unit branch_unit_chk uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .kind(kind), .seqPc(seqPc),
  .longAddr(longAddr), .cmpA(cmpA), .cmpB(cmpB), .decOperand(decOperand),
  .outValid(outValid), .nextPc(nextPc), .taken(taken), .carryOut(carryOut),
  .decResult(decResult)
);

// File: tb/tb_branch_unit.sv
`timescale 1ns/1ps
module tb_branch_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  kind = '0;
  logic [15:0] seqPc = '0, longAddr = '0, dptr = '0;
  logic [7:0]  relOff = '0, opByte = '0, addrLo = '0, accIn = '0;
  logic [7:0]  cmpA = '0, cmpB = '0, decOperand = '0;
  logic        carryIn = 1'b0, bitVal = 1'b0;
  logic        outValid, taken, carryOut;
  logic [15:0] nextPc;
  logic [7:0]  decResult;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  branch_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .kind(kind), .seqPc(seqPc),
    .relOff(relOff), .opByte(opByte), .addrLo(addrLo), .longAddr(longAddr),
    .accIn(accIn), .dptr(dptr), .carryIn(carryIn), .bitVal(bitVal),
    .cmpA(cmpA), .cmpB(cmpB), .decOperand(decOperand), .outValid(outValid),
    .nextPc(nextPc), .taken(taken), .carryOut(carryOut), .decResult(decResult)
  );

  function automatic string reqOf(input logic [3:0] k);
    case (k)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      4'd8, 4'd9: return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(output logic [15:0] ePc, output logic eTk, output logic eCy, output logic [7:0] eDec);
    logic [15:0] rel;
    logic [15:0] tgt;
    logic [7:0]  dv;
    logic        tk;
    rel = seqPc + {{8{relOff[7]}}, relOff};
    dv  = decOperand - 8'd1;
    tgt = rel;
    case (kind)
      4'd0: tk = 1'b1;
      4'd1: begin tk = 1'b1; tgt = longAddr; end
      4'd2: begin tk = 1'b1; tgt = {seqPc[15:11], opByte[7:5], addrLo}; end
      4'd3: begin tk = 1'b1; tgt = dptr + {8'd0, accIn}; end
      4'd4: tk = (accIn == 8'd0);
      4'd5: tk = (accIn != 8'd0);
      4'd6: tk = carryIn;
      4'd7: tk = !carryIn;
      4'd8: tk = bitVal;
      4'd9: tk = !bitVal;
      4'd10: tk = (cmpA != cmpB);
      4'd11: tk = (dv != 8'd0);
      default: tk = 1'b0;
    endcase
    ePc  = tk ? tgt : seqPc;
    eTk  = tk;
    eCy  = (kind == 4'd10) ? (cmpA < cmpB) : carryIn;
    eDec = (kind == 4'd11) ? dv : decOperand;
  endtask

  task automatic runOne();
    logic [15:0] ePc;
    logic        eTk, eCy;
    logic [7:0]  eDec;
    string       r;
    model(ePc, eTk, eCy, eDec);
    r = reqOf(kind);
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2", "outValid", {31'd0, outValid}, 32'd1);
    check(r, "nextPc", {16'd0, nextPc}, {16'd0, ePc});
    check(r, "taken", {31'd0, taken}, {31'd0, eTk});
    check(kind == 4'd10 ? "R10" : r, "carryOut", {31'd0, carryOut}, {31'd0, eCy});
    check(kind == 4'd11 ? "R11" : r, "decResult", {24'd0, decResult}, {24'd0, eDec});
    // idle cycle with different operands: results must hold (R2)
    inValid = 1'b0;
    seqPc = ~seqPc; longAddr = ~longAddr; decOperand = ~decOperand;
    carryIn = ~carryIn;
    @(posedge clk);
    @(negedge clk);
    check("R2", "idle outValid", {31'd0, outValid}, 32'd0);
    check("R2", "idle nextPc", {16'd0, nextPc}, {16'd0, ePc});
    check("R2", "idle taken", {31'd0, taken}, {31'd0, eTk});
    check("R2", "idle carryOut", {31'd0, carryOut}, {31'd0, eCy});
    check("R2", "idle decResult", {24'd0, decResult}, {24'd0, eDec});
  endtask

  task automatic setOps(input logic [3:0] k, input logic [15:0] pc, input logic [7:0] off);
    kind = k; seqPc = pc; relOff = off;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "outValid", {31'd0, outValid}, 32'd0);
    check("R1", "nextPc", {16'd0, nextPc}, 32'd0);
    check("R1", "taken", {31'd0, taken}, 32'd0);
    check("R1", "carryOut", {31'd0, carryOut}, 32'd0);
    check("R1", "decResult", {24'd0, decResult}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: most negative offset and wrap past FFFF
    setOps(4'd0, 16'h0010, 8'h80); runOne();
    setOps(4'd0, 16'hFFF0, 8'h20); runOne();
    // R4: long
    setOps(4'd1, 16'h1234, 8'h00); longAddr = 16'hBEEF; runOne();
    // R5: page taken from advanced PC at page boundary
    setOps(4'd2, 16'h0800, 8'h00); opByte = 8'hE1; addrLo = 8'h23; runOne();
    setOps(4'd2, 16'hF7FF, 8'h00); opByte = 8'h11; addrLo = 8'hFF; runOne();
    // R6: indirect wrap
    setOps(4'd3, 16'h0100, 8'h00); dptr = 16'hFFFF; accIn = 8'h02; runOne();
    // R7
    setOps(4'd4, 16'h0200, 8'h05); accIn = 8'h00; runOne();
    setOps(4'd5, 16'h0200, 8'h05); accIn = 8'h00; runOne();
    // R8, R9
    setOps(4'd6, 16'h0300, 8'hFE); carryIn = 1'b1; runOne();
    setOps(4'd7, 16'h0300, 8'hFE); carryIn = 1'b1; runOne();
    setOps(4'd8, 16'h0400, 8'h7F); bitVal = 1'b0; runOne();
    setOps(4'd9, 16'h0400, 8'h7F); bitVal = 1'b0; runOne();
    // R10: equal, less, greater
    setOps(4'd10, 16'h0500, 8'h10); cmpA = 8'h40; cmpB = 8'h40; carryIn = 1'b1; runOne();
    setOps(4'd10, 16'h0500, 8'h10); cmpA = 8'h01; cmpB = 8'hFF; runOne();
    setOps(4'd10, 16'h0500, 8'h10); cmpA = 8'hFF; cmpB = 8'h01; runOne();
    // R11: 00 wraps to FF and branches; 01 falls through
    setOps(4'd11, 16'h0600, 8'hF0); decOperand = 8'h00; runOne();
    setOps(4'd11, 16'h0600, 8'hF0); decOperand = 8'h01; runOne();
    // R12: unused codes
    setOps(4'd12, 16'h0700, 8'h10); runOne();
    setOps(4'd15, 16'h0700, 8'h10); runOne();

    for (int i = 0; i < 400; i++) begin
      kind = 4'($urandom_range(0, 15));
      seqPc = 16'($urandom); relOff = 8'($urandom);
      opByte = 8'($urandom); addrLo = 8'($urandom);
      longAddr = 16'($urandom); accIn = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom);
      dptr = 16'($urandom); carryIn = 1'($urandom); bitVal = 1'($urandom);
      cmpA = 8'($urandom); cmpB = ($urandom_range(0, 3) == 0) ? cmpA : 8'($urandom);
      decOperand = 8'($urandom_range(0, 3));
      runOne();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule